// File: doc/BRIEF.md
# Compact Serial Port with Register File

This block is a small asynchronous serial port for a control processor. Software talks to it through eleven word registers on a plain bus with an address, a write strobe, a read strobe and separate write and read data. Frames carry one start bit, seven or eight data bits sent least significant bit first, and one stop bit. No parity bit is ever added or checked.

Each direction has an eight-entry FIFO. A 16-bit divisor sets the bit time, which is 8 × (divisor + 1) clocks. The receiver samples eight times per bit and takes a majority vote of the three middle samples. There is one interrupt output with two sources, receive data waiting and transmit FIFO empty. An identify register reports one cause at a time. A software-driven ready-to-send output and a synchronised clear-to-send input complete the interface. Frame errors, breaks, receive timeouts and automatic flow control are not handled.

Register offsets: 0 data, 1 interrupt enable, 2 interrupt identify and flush, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 scratch, 8 direction enables, 9 short status, 10 divisor.

Top module: `lite_uart`

## Requirements
- R1: A transmitted 8-bit frame is a low start bit, the eight data bits sent least significant bit first, and a high stop bit. Each bit lasts 8 × (divisor + 1) clocks, where the divisor is the value held at offset 10.
- R2: Line control bits [1:0] select the word length: 00 selects 7 data bits and 11 selects 8. In 7-bit mode the transmitter sends bits [6:0] followed by the stop bit, and a received byte reads back with bit 7 equal to 0.
- R3: The transmit FIFO holds 8 bytes. A write to offset 0 while it is full is dropped, and the dropped byte is never sent.
- R4: Received bytes are read from offset 0 in arrival order, and each read removes one byte. Line status bit 0 is 1 while at least one received byte is waiting.
- R5: A byte that completes while the receive FIFO holds 8 bytes is discarded and sets line status bit 1. A read of line status clears that bit.
- R6: Interrupt enable bit 0 enables the receive source and bit 1 enables the transmit source. The irq output rises only when bits 2 and 3 are both 1.
- R7: The identify register at offset 2 reads 0x04 when an enabled receive cause is pending. It reads 0x02 when only an enabled transmit cause is pending, meaning the transmit FIFO is empty. It reads 0x01 when neither is pending. Receive has priority over transmit.
- R8: A write to offset 2 with bit 1 set empties the receive FIFO. A write with bit 2 set empties the transmit FIFO.
- R9: Line status bit 5 is 1 while the transmit FIFO has room. Bit 6 is 1 when the transmit FIFO is empty and no frame is being shifted out.
- R10: Offset 8 bit 0 enables the receiver and bit 1 enables the transmitter, and both reset to 1. With the receiver off, frames on rxd are ignored. With the transmitter off, txd stays high and queued bytes are held until it is turned on.
- R11: Modem control bit 1 drives rts_o. Modem status bit 5 shows cts_i after two clock cycles of synchronisation.
- R12: Bits that are not implemented ignore writes and read as 0. Interrupt enable keeps 4 bits, line control keeps 2 bits, and scratch keeps 8 bits.
- R13: After reset, txd is 1, irq is 0, rts_o is 0, line status reads 0x60 and offset 8 reads 0x03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register offset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe; carries the pop and clear side effects |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr, combinational |
| txd | output | 1 | Serial transmit line, idles high |
| rxd | input | 1 | Serial receive line |
| rts_o | output | 1 | Software-driven ready-to-send |
| cts_i | input | 1 | Clear-to-send input, readable only |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that neither FIFO count goes above 8 and that a write to a full transmit FIFO leaves it full. They also check that overrun sets only when the receive FIFO was full, that rts_o follows each modem control write, that the line is high at the end of every frame, and that the line stays high while the transmitter is disabled and idle. The bench scenarios cover what needs whole frames or register sequences. These are bit timing at two divisors, the 7-bit framing in both directions, byte order through a full FIFO, clearing overrun by a read, interrupt gating and cause priority, and the flushes.

// File: rtl/lite_uart.sv
`timescale 1ns/1ps
module lite_uart #(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  parameter int DIV_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          txd,
  input  logic          rxd,
  output logic          rts_o,
  input  logic          cts_i,
  output logic          irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  localparam logic [3:0] A_DATA  = 4'd0;
  localparam logic [3:0] A_IEN   = 4'd1;
  localparam logic [3:0] A_ISTAT = 4'd2;
  localparam logic [3:0] A_LINE  = 4'd3;
  localparam logic [3:0] A_MCTL  = 4'd4;
  localparam logic [3:0] A_LSTAT = 4'd5;
  localparam logic [3:0] A_MSTAT = 4'd6;
  localparam logic [3:0] A_SCR   = 4'd7;
  localparam logic [3:0] A_XCTL  = 4'd8;
  localparam logic [3:0] A_XSTAT = 4'd9;
  localparam logic [3:0] A_BAUD  = 4'd10;

  logic [3:0]       ien_q;
  logic [1:0]       line_q;
  logic             rts_q;
  logic [7:0]       scr_q;
  logic [1:0]       xctl_q;
  logic [DIV_W-1:0] div_q;
  logic             ovr_q;
  logic [1:0]       cts_s;

  wire wr_data  = wr_en && addr == A_DATA;
  wire flush_rx = wr_en && addr == A_ISTAT && wdata[1];
  wire flush_tx = wr_en && addr == A_ISTAT && wdata[2];
  wire word8    = line_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      line_q <= '0;
      rts_q  <= 1'b0;
      scr_q  <= '0;
      xctl_q <= 2'b11;
      div_q  <= '0;
      cts_s  <= '0;
    end else begin
      cts_s <= {cts_s[0], cts_i};
      if (wr_en) begin
        case (addr)
          A_IEN:   ien_q  <= wdata[3:0];
          A_LINE:  line_q <= wdata[1:0];
          A_MCTL:  rts_q  <= wdata[1];
          A_SCR:   scr_q  <= wdata[7:0];
          A_XCTL:  xctl_q <= wdata[1:0];
          A_BAUD:  div_q  <= wdata[DIV_W-1:0];
          default: ;
        endcase
      end
    end
  end
  assign rts_o = rts_q;

  logic [DIV_W-1:0] bcnt;
  wire tick = bcnt >= div_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= '0;
    else if (tick) bcnt <= '0;
    else           bcnt <= bcnt + 1'b1;
  end

  // transmit FIFO
  logic [7:0]    tx_mem [DEPTH];
  logic [PW-1:0] tx_rd, tx_wr;
  logic [CW-1:0] tx_cnt;
  logic          tx_busy;
  logic [9:0]    tx_frame;
  logic [3:0]    tx_left;
  logic [2:0]    tx_sub;

  wire tx_push  = wr_data && tx_cnt != FULL;
  wire tx_start = tick && !tx_busy && xctl_q[1] && tx_cnt != '0;

  always_ff @(posedge clk) if (tx_push) tx_mem[tx_wr] <= wdata[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_rd <= '0; tx_wr <= '0; tx_cnt <= '0;
    end else if (flush_tx) begin
      tx_rd <= '0; tx_wr <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push)  tx_wr <= tx_wr + 1'b1;
      if (tx_start) tx_rd <= tx_rd + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_start);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy  <= 1'b0;
      tx_frame <= '1;
      tx_left  <= '0;
      tx_sub   <= '0;
    end else if (tx_start) begin
      tx_busy  <= 1'b1;
      tx_sub   <= '0;
      tx_left  <= word8 ? 4'd10 : 4'd9;
      tx_frame <= word8 ? {1'b1, tx_mem[tx_rd], 1'b0}
                        : {2'b11, tx_mem[tx_rd][6:0], 1'b0};
    end else if (tick && tx_busy) begin
      tx_sub <= tx_sub + 1'b1;
      if (tx_sub == 3'd7) begin
        tx_frame <= {1'b1, tx_frame[9:1]};
        tx_left  <= tx_left - 1'b1;
        if (tx_left == 4'd1) tx_busy <= 1'b0;
      end
    end
  end
  assign txd = tx_frame[0];

  // receiver
  logic [1:0] rx_s;
  logic       rx_busy;
  logic [2:0] rx_sub;
  logic [3:0] rx_idx;
  logic [1:0] rx_v;
  logic [7:0] rx_sh;

  wire       rx_b     = rx_s[1];
  wire       maj      = (rx_v[0] & rx_v[1]) | (rx_v[0] & rx_b) | (rx_v[1] & rx_b);
  wire [3:0] last_idx = word8 ? 4'd9 : 4'd8;
  wire       rx_done  = rx_busy && tick && rx_sub == 3'd5 && rx_idx == last_idx;
  wire [7:0] rx_byte  = word8 ? rx_sh : {1'b0, rx_sh[7:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s    <= 2'b11;
      rx_busy <= 1'b0;
      rx_sub  <= '0;
      rx_idx  <= '0;
      rx_v    <= '0;
      rx_sh   <= '0;
    end else begin
      rx_s <= {rx_s[0], rxd};
      if (!xctl_q[0]) begin
        rx_busy <= 1'b0;
      end else if (tick) begin
        if (!rx_busy) begin
          if (!rx_b) begin
            rx_busy <= 1'b1;
            rx_sub  <= 3'd1;
            rx_idx  <= '0;
          end
        end else begin
          rx_sub <= rx_sub + 1'b1;
          if (rx_sub == 3'd3) rx_v[0] <= rx_b;
          if (rx_sub == 3'd4) rx_v[1] <= rx_b;
          if (rx_sub == 3'd5) begin
            if (rx_idx == '0 && maj)     rx_busy <= 1'b0;
            else if (rx_idx == last_idx) rx_busy <= 1'b0;
            else if (rx_idx != '0)       rx_sh   <= {maj, rx_sh[7:1]};
          end
          if (rx_sub == 3'd7) rx_idx <= rx_idx + 1'b1;
        end
      end
    end
  end

  // receive FIFO
  logic [7:0]    rx_mem [DEPTH];
  logic [PW-1:0] rx_rd, rx_wr;
  logic [CW-1:0] rx_cnt;

  wire rx_push = rx_done && rx_cnt != FULL;
  wire rx_lost = rx_done && rx_cnt == FULL;
  wire rx_pop  = rd_en && addr == A_DATA && rx_cnt != '0;

  always_ff @(posedge clk) if (rx_push) rx_mem[rx_wr] <= rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rd <= '0; rx_wr <= '0; rx_cnt <= '0;
    end else if (flush_rx) begin
      rx_rd <= '0; rx_wr <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wr <= rx_wr + 1'b1;
      if (rx_pop)  rx_rd <= rx_rd + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         ovr_q <= 1'b0;
    else if (rx_lost)                   ovr_q <= 1'b1;
    else if (rd_en && addr == A_LSTAT)  ovr_q <= 1'b0;
  end

  wire rx_avail = rx_cnt != '0;
  wire tx_room  = tx_cnt != FULL;
  wire tx_idle  = tx_cnt == '0 && !tx_busy;
  wire rx_cause = ien_q[0] && rx_avail;
  wire tx_cause = ien_q[1] && tx_cnt == '0;
  wire [2:0] istat = rx_cause ? 3'b100 : tx_cause ? 3'b010 : 3'b001;

  assign irq = (rx_cause || tx_cause) && ien_q[2] && ien_q[3];

  always_comb begin
    rdata = '0;
    case (addr)
      A_DATA:  rdata = rx_avail ? DW'(rx_mem[rx_rd]) : '0;
      A_IEN:   rdata = DW'(ien_q);
      A_ISTAT: rdata = DW'(istat);
      A_LINE:  rdata = DW'(line_q);
      A_MCTL:  rdata = DW'({rts_q, 1'b0});
      A_LSTAT: rdata = DW'({tx_idle, tx_room, 3'b000, ovr_q, rx_avail});
      A_MSTAT: rdata = DW'({cts_s[1], 5'b00000});
      A_SCR:   rdata = DW'(scr_q);
      A_XCTL:  rdata = DW'(xctl_q);
      A_XSTAT: rdata = DW'({tx_room, rx_avail});
      A_BAUD:  rdata = DW'(div_q);
      default: rdata = '0;
    endcase
  end

  // R3
  tx_level_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= FULL);
  // R5
  rx_level_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_cnt <= FULL);
  // R3
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && tx_cnt == FULL && !tx_start && !flush_tx) |=> tx_cnt == FULL);
  // R5
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(rx_cnt) == FULL);
  // R11
  rts_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MCTL) |=> rts_o == $past(wdata[1]));
  // R1
  stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> txd);
  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xctl_q[1] && !tx_busy) |=> txd);
endmodule

// File: tb/lite_uart_bench.sv
`timescale 1ns/1ps
module lite_uart_bench;
  localparam int DIVV = 3;
  localparam int BT   = 8 * (DIVV + 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        txd, rts_o, irq;
  logic        rxd = 1'b1, cts_i = 1'b0;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  lite_uart u_lite_uart (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .txd(txd), .rxd(rxd),
    .rts_o(rts_o), .cts_i(cts_i), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] d, input int nb);
    @(negedge clk); rxd = 1'b0;
    repeat (BT) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i];
      repeat (BT) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (BT) @(negedge clk);
  endtask

  task automatic grab_tx(input int nb, output logic [7:0] d, output logic stop);
    int w;
    d = '0; stop = 1'b0; w = 0;
    while (txd !== 1'b0 && w < 4000) begin @(negedge clk); w++; end
    repeat (BT / 2) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      repeat (BT) @(negedge clk);
      d[i] = txd;
    end
    repeat (BT) @(negedge clk);
    stop = txd;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int i = 0; i < 400; i++) begin
      bus_rd(4'd5, v);
      if (v[6]) break;
    end
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R13 txd", txd, 1); chk("R13 irq", irq, 0); chk("R13 rts", rts_o, 0);
    bus_rd(4'd5, v); chk("R13 line status", v, 16'h0060);
    bus_rd(4'd8, v); chk("R13 enables", v, 16'h0003);
    bus_rd(4'd2, v); chk("R7 identify idle", v, 16'h0001);
  endtask

  task automatic t_masks();
    logic [15:0] v;
    bus_wr(4'd7, 16'hFFFF); bus_rd(4'd7, v); chk("R12 scratch", v, 16'h00FF);
    bus_wr(4'd1, 16'hFFF0); bus_rd(4'd1, v); chk("R12 enable width", v, 16'h0000);
    bus_wr(4'd3, 16'hFFFC); bus_rd(4'd3, v); chk("R12 line width", v, 16'h0000);
    bus_wr(4'd6, 16'hFFFF); bus_rd(4'd6, v); chk("R12 status ignores write", v, 16'h0000);
    bus_wr(4'd3, 16'h0003);
  endtask

  task automatic t_tx_frame();
    logic [7:0] d; logic s; int n;
    bus_wr(4'd10, 16'd1);
    bus_wr(4'd0, 16'h0055);
    n = 0;
    while (txd !== 1'b0 && n < 1000) begin @(negedge clk); n++; end
    n = 0;
    while (txd === 1'b0 && n < 1000) begin @(negedge clk); n++; end
    chk("R1 bit time divisor 1", n, 16);
    wait_idle();
    bus_wr(4'd10, DIVV);
    bus_wr(4'd0, 16'h0055);
    n = 0;
    while (txd !== 1'b0 && n < 1000) begin @(negedge clk); n++; end
    n = 0;
    while (txd === 1'b0 && n < 1000) begin @(negedge clk); n++; end
    chk("R1 bit time divisor 3", n, BT);
    wait_idle();
    bus_wr(4'd0, 16'h00A5);
    grab_tx(8, d, s);
    chk("R1 tx data", d, 8'hA5); chk("R1 tx stop", s, 1);
    wait_idle();
  endtask

  task automatic t_tx7();
    logic [7:0] d; logic s;
    bus_wr(4'd3, 16'h0000);
    bus_wr(4'd0, 16'h0080);
    grab_tx(7, d, s);
    chk("R2 tx 7-bit data", d, 8'h00); chk("R2 tx 7-bit stop", s, 1);
    wait_idle();
    bus_wr(4'd3, 16'h0003);
  endtask

  task automatic t_rx();
    logic [15:0] v;
    send_rx(8'h3C, 8); send_rx(8'hC3, 8);
    bus_rd(4'd5, v); chk("R4 data ready", v[0], 1);
    bus_rd(4'd0, v); chk("R4 first byte", v, 16'h003C);
    bus_rd(4'd0, v); chk("R4 second byte", v, 16'h00C3);
    bus_rd(4'd5, v); chk("R4 drained", v[0], 0);
  endtask

  task automatic t_rx7();
    logic [15:0] v;
    bus_wr(4'd3, 16'h0000);
    send_rx(8'h7F, 7);
    bus_rd(4'd0, v); chk("R2 rx 7-bit byte", v, 16'h007F);
    bus_wr(4'd3, 16'h0003);
  endtask

  task automatic t_overrun();
    logic [15:0] v;
    for (int i = 0; i < 9; i++) send_rx(8'(i * 17 + 1), 8);
    bus_rd(4'd5, v); chk("R5 overrun set", v[1:0], 2'b11);
    bus_rd(4'd5, v); chk("R5 overrun cleared by read", v[1:0], 2'b01);
    for (int i = 0; i < 8; i++) begin
      bus_rd(4'd0, v); chk("R5 kept bytes in order", v, 16'(i * 17 + 1));
    end
    bus_rd(4'd5, v); chk("R5 ninth byte discarded", v[0], 0);
  endtask

  task automatic t_txfull();
    logic [15:0] v; logic [7:0] d; logic s; logic stayed;
    bus_wr(4'd8, 16'h0001);
    for (int i = 0; i < 9; i++) bus_wr(4'd0, 16'(8'h10 + i));
    bus_rd(4'd5, v); chk("R9 full no room not idle", v, 16'h0000);
    stayed = 1'b1;
    repeat (400) begin @(negedge clk); if (txd !== 1'b1) stayed = 1'b0; end
    chk("R10 tx disabled holds line", stayed, 1);
    bus_wr(4'd8, 16'h0003);
    for (int i = 0; i < 8; i++) begin
      grab_tx(8, d, s);
      chk("R3 queued byte", d, 8'(8'h10 + i));
    end
    repeat (3 * BT) @(negedge clk);
    chk("R3 dropped byte not sent", txd, 1);
    bus_rd(4'd5, v); chk("R9 idle after drain", v, 16'h0060);
  endtask

  task automatic t_rxoff();
    logic [15:0] v;
    bus_wr(4'd8, 16'h0002);
    send_rx(8'h5A, 8);
    bus_rd(4'd5, v); chk("R10 rx disabled ignores frame", v[0], 0);
    bus_wr(4'd8, 16'h0003);
  endtask

  task automatic t_flush();
    logic [15:0] v;
    send_rx(8'h11, 8); send_rx(8'h22, 8);
    bus_wr(4'd8, 16'h0001);
    bus_wr(4'd0, 16'h0033); bus_wr(4'd0, 16'h0044);
    bus_rd(4'd5, v); chk("R8 before flush", v, 16'h0021);
    bus_wr(4'd2, 16'h0002);
    bus_rd(4'd5, v); chk("R8 rx flushed", v, 16'h0020);
    bus_wr(4'd2, 16'h0004);
    bus_rd(4'd5, v); chk("R8 tx flushed", v, 16'h0060);
    bus_wr(4'd8, 16'h0003);
    repeat (3 * BT) @(negedge clk);
    chk("R8 flushed bytes not sent", txd, 1);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    bus_wr(4'd1, 16'h0003);
    send_rx(8'h66, 8);
    chk("R6 gate bits clear", irq, 0);
    bus_rd(4'd2, v); chk("R7 rx priority", v, 16'h0004);
    bus_wr(4'd1, 16'h000F);
    chk("R6 irq with gate", irq, 1);
    bus_rd(4'd0, v);
    bus_rd(4'd2, v); chk("R7 tx cause", v, 16'h0002);
    chk("R6 irq tx", irq, 1);
    bus_wr(4'd1, 16'h000D);
    bus_rd(4'd2, v); chk("R7 none pending", v, 16'h0001);
    chk("R6 irq low", irq, 0);
    bus_wr(4'd1, 16'h0000);
  endtask

  task automatic t_modem();
    logic [15:0] v;
    bus_wr(4'd4, 16'h0002); chk("R11 rts high", rts_o, 1);
    bus_rd(4'd4, v); chk("R11 modem control readback", v, 16'h0002);
    cts_i = 1'b1; repeat (3) @(negedge clk);
    bus_rd(4'd6, v); chk("R11 cts seen", v, 16'h0020);
    cts_i = 1'b0; repeat (3) @(negedge clk);
    bus_rd(4'd6, v); chk("R11 cts low", v, 16'h0000);
    bus_wr(4'd4, 16'h0000); chk("R11 rts low", rts_o, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired (all requirements)");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    bus_wr(4'd10, DIVV);
    bus_wr(4'd3, 16'h0003);
    t_masks();
    t_tx_frame();
    t_tx7();
    t_rx();
    t_rx7();
    t_overrun();
    t_txfull();
    t_rxoff();
    t_flush();
    t_irq();
    t_modem();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule